// File: doc/BRIEF.md
# Two-slot transmit frame buffer

This block stages outgoing Ethernet frames between a CPU and a downstream MAC. Software reaches it through a small word-addressed register port. It picks one of two frame slots, pushes the frame into that slot as 32-bit words through a single data address, writes the frame's byte count into the slot's length register, and then sets the slot's start bit. The buffer then hands the stored bytes, one per cycle at most, to a byte-wide valid/ready stream. It raises a last marker on the final byte and drops the start bit once that byte has been taken.

The two slots share the output stream. While one frame is being sent, software can fill and arm the other slot. Armed frames leave in the order their start bits were set. Preamble, frame check sequence, padding and line timing belong to the MAC downstream. Register writes take effect at the clock edge that samples them. A read returns its data one cycle after the read strobe.

Top module: `tx_slot_buf`

## Requirements
- R1: After reset the stream is idle (`tx_valid` low), both slots read as not busy, the slot-select, length and flag registers read 0, and `cpu_rdata` is 0.
- R2: Address 0 holds the slot select in bit 0 (0 = slot 0, 1 = slot 1). Writing it rewinds the fill position of the newly selected slot to its first word.
- R3: Each write to address 1 stores a word at the selected slot's fill position and then advances that position. Within a word, byte k of the frame sits in bits 8*(k mod 4)+7 down to 8*(k mod 4) of word k/4, so the byte order is little-endian.
- R4: Address 2 holds the byte length of slot 0 and address 3 holds it for slot 1. Exactly that many bytes are sent, and `tx_last` is high with the final one. Any byte lanes past the length in the last word are never sent.
- R5: Bit 0 of address 4 controls slot 0 and bit 0 of address 5 controls slot 1. Writing 1 arms the slot. The bit reads 1 from that write until the slot's last byte is accepted, and reads 0 afterwards.
- R6: An arm request for a slot whose length is 0 is ignored. The slot stays idle and nothing is sent.
- R7: When both slots are armed, the frame armed first is sent completely before any byte of the other frame.
- R8: A byte moves only on a cycle with both `tx_valid` and `tx_ready` high. While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_last` hold still.
- R9: While a slot is busy, data writes aimed at it and writes to its length register are ignored. A blocked data write sets bit 0 of the flag register at address 6, and that bit stays set until it is cleared.
- R10: A length write larger than the slot capacity (MAX_BYTES, default 2048) stores MAX_BYTES and sets bit 1 of the flag register. A length of exactly MAX_BYTES does not set the flag. Writing 1 to a flag bit at address 6 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 3 | Word address of the register access |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_rd | input | 1 | Read strobe; data valid the next cycle |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data of the last read |
| tx_valid | output | 1 | A frame byte is offered |
| tx_data | output | 8 | Offered frame byte |
| tx_last | output | 1 | Offered byte is the last of its frame |
| tx_ready | input | 1 | Downstream accepts the offered byte |

## Verification
A wrong fill or read position shows up directly at the stream. The first byte after a slip comes out with the wrong value or in the wrong lane, one cycle after the byte ahead of it was accepted. A wrong length or busy state shows up in two ways: `tx_last` appears on the wrong byte, or `tx_valid` stays high or drops too early at the frame boundary. The control bit readback shows the same fault on the next read. Slot-ordering faults show at the first byte of the second frame, which must come in the cycle right after the first frame's last byte is taken.

// File: rtl/tfb_pkg.sv
`timescale 1ns/1ps
package tfb_pkg;
  localparam int NSLOT  = 2;
  localparam int ADDR_W = 3;
  // register word addresses
  localparam int A_SEL  = 0;
  localparam int A_DATA = 1;
  localparam int A_LEN0 = 2;  // slot s length at A_LEN0 + s
  localparam int A_CTL0 = 4;  // slot s control at A_CTL0 + s
  localparam int A_FLAG = 6;
  // flag bit positions
  localparam int F_BUSYWR = 0;
  localparam int F_CLAMP  = 1;
endpackage

// File: rtl/tfb_regs.sv
`timescale 1ns/1ps
module tfb_regs import tfb_pkg::*; #(
  parameter  int MAX_BYTES = 2048,
  localparam int WORDS = MAX_BYTES / 4,
  localparam int WA_W  = $clog2(WORDS),
  localparam int WP_W  = WA_W + 1,
  localparam int MA_W  = WA_W + 1,
  localparam int LEN_W = $clog2(MAX_BYTES) + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             cpu_addr,
  input  logic                          cpu_wr,
  input  logic                          cpu_rd,
  input  logic [31:0]                   cpu_wdata,
  output logic [31:0]                   cpu_rdata,
  input  logic [NSLOT-1:0]              slot_busy,
  input  logic                          done,
  input  logic                          done_slot,
  output logic [NSLOT-1:0][LEN_W-1:0]   len_q,
  output logic [NSLOT-1:0]              slot_start,
  output logic                          mem_we,
  output logic [MA_W-1:0]               mem_waddr,
  output logic [31:0]                   mem_wdata
);
  logic                          sel_q, sel_n;
  logic [NSLOT-1:0][WP_W-1:0]    wptr_q, wptr_n;
  logic [NSLOT-1:0][LEN_W-1:0]   len_n;
  logic [1:0]                    flag_q, flag_n;
  logic [31:0]                   rdata_n;
  logic                          hit_sel, hit_data, hit_flag;
  logic                          data_blocked, data_ok, too_long;
  logic [LEN_W-1:0]              len_val;

  // arm pulses, one per slot
  for (genvar g = 0; g < NSLOT; g++) begin : g_arm
    assign slot_start[g] = cpu_wr && (cpu_addr == ADDR_W'(A_CTL0 + g)) &&
                           cpu_wdata[0] && !slot_busy[g] && (len_q[g] != '0);
  end

  always_comb begin
    hit_sel      = cpu_wr && (cpu_addr == ADDR_W'(A_SEL));
    hit_data     = cpu_wr && (cpu_addr == ADDR_W'(A_DATA));
    hit_flag     = cpu_wr && (cpu_addr == ADDR_W'(A_FLAG));
    data_blocked = hit_data && slot_busy[sel_q];
    data_ok      = hit_data && !slot_busy[sel_q] && (wptr_q[sel_q] < WP_W'(WORDS));
    too_long     = cpu_wdata > 32'(MAX_BYTES);
    len_val      = too_long ? LEN_W'(MAX_BYTES) : cpu_wdata[LEN_W-1:0];

    sel_n  = hit_sel ? cpu_wdata[0] : sel_q;
    flag_n = hit_flag ? (flag_q & ~cpu_wdata[1:0]) : flag_q;
    if (data_blocked) flag_n[F_BUSYWR] = 1'b1;

    for (int s = 0; s < NSLOT; s++) begin
      len_n[s]  = len_q[s];
      wptr_n[s] = wptr_q[s];
      if (cpu_wr && (cpu_addr == ADDR_W'(A_LEN0 + s)) && !slot_busy[s]) begin
        len_n[s] = len_val;
        if (too_long) flag_n[F_CLAMP] = 1'b1;
      end
      if (hit_sel && (cpu_wdata[0] == 1'(s)))
        wptr_n[s] = '0;
      else if (done && (done_slot == 1'(s)))
        wptr_n[s] = '0;
      else if (data_ok && (sel_q == 1'(s)))
        wptr_n[s] = wptr_q[s] + WP_W'(1);
    end

    case (cpu_addr)
      ADDR_W'(A_SEL):      rdata_n = {31'd0, sel_q};
      ADDR_W'(A_LEN0):     rdata_n = 32'(len_q[0]);
      ADDR_W'(A_LEN0 + 1): rdata_n = 32'(len_q[1]);
      ADDR_W'(A_CTL0):     rdata_n = {31'd0, slot_busy[0]};
      ADDR_W'(A_CTL0 + 1): rdata_n = {31'd0, slot_busy[1]};
      ADDR_W'(A_FLAG):     rdata_n = {30'd0, flag_q};
      default:             rdata_n = 32'd0;
    endcase
  end

  assign mem_we    = data_ok;
  assign mem_waddr = {sel_q, wptr_q[sel_q][WA_W-1:0]};
  assign mem_wdata = cpu_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= 1'b0;
      wptr_q    <= '0;
      len_q     <= '0;
      flag_q    <= '0;
      cpu_rdata <= '0;
    end else begin
      sel_q  <= sel_n;
      wptr_q <= wptr_n;
      len_q  <= len_n;
      flag_q <= flag_n;
      if (cpu_rd) cpu_rdata <= rdata_n;
    end
  end
endmodule

// File: rtl/tfb_store.sv
`timescale 1ns/1ps
module tfb_store import tfb_pkg::*; #(
  parameter  int MAX_BYTES = 2048,
  localparam int WORDS = MAX_BYTES / 4,
  localparam int DEPTH = NSLOT * WORDS,
  localparam int MA_W  = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [MA_W-1:0] waddr,
  input  logic [31:0]     wdata,
  input  logic [MA_W-1:0] raddr,
  output logic [31:0]     rword
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rword = mem[raddr];
endmodule

// File: rtl/tfb_seq.sv
`timescale 1ns/1ps
module tfb_seq import tfb_pkg::*; #(
  parameter  int MAX_BYTES = 2048,
  localparam int BI_W  = $clog2(MAX_BYTES),
  localparam int LEN_W = BI_W + 1,
  localparam int MA_W  = BI_W - 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NSLOT-1:0]            slot_start,
  input  logic [NSLOT-1:0][LEN_W-1:0] len_q,
  input  logic [31:0]                 rword,
  output logic [MA_W-1:0]             raddr,
  output logic                        tx_valid,
  output logic [7:0]                  tx_data,
  output logic                        tx_last,
  input  logic                        tx_ready,
  output logic [NSLOT-1:0]            slot_busy,
  output logic                        done,
  output logic                        done_slot
);
  logic [NSLOT-1:0] busy_q, busy_n;
  logic             act_q, act_n;
  logic             cur_q, cur_n;
  logic [BI_W-1:0]  bidx_q, bidx_n;
  logic [LEN_W-1:0] cur_len;
  logic             fire;

  always_comb begin
    cur_len  = len_q[cur_q];
    tx_valid = act_q;
    tx_last  = act_q && ({1'b0, bidx_q} == (cur_len - LEN_W'(1)));
    tx_data  = rword[{bidx_q[1:0], 3'b000} +: 8];
    raddr    = {cur_q, bidx_q[BI_W-1:2]};
    fire     = act_q && tx_ready;
    done     = fire && tx_last;
    done_slot = cur_q;

    busy_n = busy_q | slot_start;
    if (done) busy_n[cur_q] = 1'b0;

    act_n  = act_q;
    cur_n  = cur_q;
    bidx_n = bidx_q;
    if (done) begin
      bidx_n = '0;
      if (busy_n[~cur_q]) cur_n = ~cur_q;   // the other slot was armed later
      else                act_n = 1'b0;
    end else if (fire) begin
      bidx_n = bidx_q + BI_W'(1);
    end else if (!act_q && (slot_start != '0)) begin
      act_n  = 1'b1;
      cur_n  = slot_start[1];
      bidx_n = '0;
    end
  end

  assign slot_busy = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      act_q  <= 1'b0;
      cur_q  <= 1'b0;
      bidx_q <= '0;
    end else begin
      busy_q <= busy_n;
      act_q  <= act_n;
      cur_q  <= cur_n;
      bidx_q <= bidx_n;
    end
  end
endmodule

// File: rtl/tx_slot_buf.sv
`timescale 1ns/1ps
module tx_slot_buf import tfb_pkg::*; #(
  parameter int MAX_BYTES = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_ready
);
  localparam int WORDS = MAX_BYTES / 4;
  localparam int MA_W  = $clog2(WORDS) + 1;
  localparam int LEN_W = $clog2(MAX_BYTES) + 1;

  logic [1:0]                  rst_pipe;
  logic                        rst_core_n;
  logic [NSLOT-1:0]            slot_busy, slot_start;
  logic [NSLOT-1:0][LEN_W-1:0] len_q;
  logic                        done, done_slot, mem_we;
  logic [MA_W-1:0]             mem_waddr, mem_raddr;
  logic [31:0]                 mem_wdata, mem_rword;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  tfb_regs #(.MAX_BYTES(MAX_BYTES)) u_regs (
    .clk(clk), .rst_n(rst_core_n),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .slot_busy(slot_busy), .done(done), .done_slot(done_slot),
    .len_q(len_q), .slot_start(slot_start),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  tfb_store #(.MAX_BYTES(MAX_BYTES)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rword(mem_rword)
  );

  tfb_seq #(.MAX_BYTES(MAX_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_core_n),
    .slot_start(slot_start), .len_q(len_q), .rword(mem_rword),
    .raddr(mem_raddr), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_last(tx_last), .tx_ready(tx_ready), .slot_busy(slot_busy),
    .done(done), .done_slot(done_slot)
  );
endmodule

// File: rtl/tx_slot_buf_chk.sv
`timescale 1ns/1ps
module tx_slot_buf_chk import tfb_pkg::*; #(
  parameter  int MAX_BYTES = 2048,
  localparam int LEN_W = $clog2(MAX_BYTES) + 1
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        tx_valid,
  input logic                        tx_ready,
  input logic                        tx_last,
  input logic [7:0]                  tx_data,
  input logic [NSLOT-1:0]            busy,
  input logic [NSLOT-1:0]            start,
  input logic [NSLOT-1:0][LEN_W-1:0] lens,
  input logic                        cpu_wr,
  input logic [ADDR_W-1:0]           cpu_addr
);
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  a_r4_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  a_r5_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (busy != '0));

  a_r5_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last && (start == '0)) |=>
      ($countones(busy) == $past($countones(busy)) - 1));

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    a_r5_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      start[g] |=> busy[g]);

    a_r10_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
      lens[g] <= LEN_W'(MAX_BYTES));

    a_r9_len_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (busy[g] && cpu_wr && (cpu_addr == ADDR_W'(A_LEN0 + g))) |=> $stable(lens[g]));
  end
endmodule

bind tx_slot_buf tx_slot_buf_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_last(tx_last), .tx_data(tx_data), .busy(slot_busy), .start(slot_start),
  .lens(len_q), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr)
);

// File: tb/tx_slot_buf_bench.sv
`timescale 1ns/1ps
module tx_slot_buf_bench;
  import tfb_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  addr;
  logic        wr, rd, tx_ready;
  logic [31:0] wdata, rdata;
  logic        tx_valid, tx_last;
  logic [7:0]  tx_data;
  int          total = 0;
  int          bad = 0;
  bit          finished = 0;

  always #2.5 clk = ~clk;

  tx_slot_buf #(.MAX_BYTES(2048)) u_tx_slot_buf (
    .clk(clk), .rst_n(rst_n), .cpu_addr(addr), .cpu_wr(wr), .cpu_rd(rd),
    .cpu_wdata(wdata), .cpu_rdata(rdata), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
  );

  // [25] stall, [24] slot, [23:16] first byte, [15:0] length
  localparam logic [31:0] VEC [6] = '{
    32'h0010_0001, 32'h0320_0004, 32'h0030_0005,
    32'h0341_0007, 32'h0280_0040, 32'h0100_0800
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int a, input logic [31:0] d);
    addr = 3'(a); wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input int a, output logic [31:0] d);
    addr = 3'(a); rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic load(input bit slot, input int len, input logic [7:0] seed);
    wr_reg(A_SEL, {31'd0, slot});
    for (int w = 0; w < (len + 3) / 4; w++) begin
      logic [31:0] word;
      for (int b = 0; b < 4; b++) begin
        int k = 4 * w + b;
        word[8*b +: 8] = (k < len) ? seed + 8'(k) : 8'hEE;
      end
      wr_reg(A_DATA, word);
    end
    wr_reg(A_LEN0 + slot, 32'(len));
  endtask

  task automatic drain(input int n, input logic [7:0] seed, input bit stall,
                       input string req);
    for (int i = 0; i < n; i++) begin
      logic [7:0] expb;
      int wt = 0;
      while (!tx_valid && wt < 64) begin @(negedge clk); wt++; end
      if (!tx_valid) begin
        chk(1'b0, req, 32'd0, 32'd1);
        return;
      end
      if (stall) begin
        logic [7:0] held;
        held = tx_data;
        @(negedge clk);
        chk(tx_valid && tx_data == held, "R8", {24'd0, tx_data}, {24'd0, held});
      end
      expb = seed + 8'(i);
      chk(tx_data == expb, req, {24'd0, tx_data}, {24'd0, expb});
      chk(tx_last == (i == n - 1), "R4", {31'd0, tx_last}, {31'd0, (i == n - 1)});
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; addr = '0; wr = 1'b0; rd = 1'b0; wdata = '0; tx_ready = 1'b0;
    repeat (4) @(negedge clk);
    chk(tx_valid == 1'b0, "R1 idle in reset", {31'd0, tx_valid}, 32'd0);
    chk(rdata == 32'd0, "R1 rdata", rdata, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(tx_valid == 1'b0, "R1 idle after reset", {31'd0, tx_valid}, 32'd0);
    for (int a = 0; a <= A_FLAG; a++) begin
      rd_reg(a, r);
      chk(r == 32'd0, "R1 register", r, 32'd0);
    end

    // table of frames
    for (int v = 0; v < 6; v++) begin
      bit          s  = VEC[v][24];
      bit          st = VEC[v][25];
      logic [7:0]  sd = VEC[v][23:16];
      int          ln = int'(VEC[v][15:0]);
      wr_reg(A_SEL, {31'd0, s});
      wr_reg(A_DATA, 32'hDEAD_BEEF);          // junk before rewind
      load(s, ln, sd);                         // re-selects: fill rewinds
      rd_reg(A_SEL, r);
      chk(r == {31'd0, s}, "R2 select readback", r, {31'd0, s});
      wr_reg(A_CTL0 + s, 32'd1);
      rd_reg(A_CTL0 + s, r);
      chk(r == 32'd1, "R5 busy while pending", r, 32'd1);
      drain(ln, sd, st, "R3 byte value");
      chk(tx_valid == 1'b0, "R4 nothing past length", {31'd0, tx_valid}, 32'd0);
      rd_reg(A_CTL0 + s, r);
      chk(r == 32'd0, "R5 busy cleared", r, 32'd0);
    end
    rd_reg(A_FLAG, r);
    chk(r == 32'd0, "R10 exact capacity not flagged", r, 32'd0);

    // R7: slot 1 armed before slot 0
    load(1'b1, 3, 8'hA0);
    load(1'b0, 2, 8'hB0);
    wr_reg(A_CTL0 + 1, 32'd1);
    wr_reg(A_CTL0, 32'd1);
    rd_reg(A_CTL0, r);
    chk(r == 32'd1, "R7 second slot pending", r, 32'd1);
    drain(3, 8'hA0, 1'b0, "R7 first armed first");
    drain(2, 8'hB0, 1'b0, "R7 second follows");
    chk(tx_valid == 1'b0, "R7 idle after both", {31'd0, tx_valid}, 32'd0);

    // R9: writes into a busy slot
    load(1'b0, 4, 8'h50);
    wr_reg(A_CTL0, 32'd1);
    wr_reg(A_SEL, 32'd0);
    wr_reg(A_DATA, 32'hFFFF_FFFF);
    wr_reg(A_LEN0, 32'd1);
    rd_reg(A_FLAG, r);
    chk(r == 32'd1, "R9 error flag", r, 32'd1);
    rd_reg(A_LEN0, r);
    chk(r == 32'd4, "R9 length kept", r, 32'd4);
    drain(4, 8'h50, 1'b0, "R9 frame intact");
    chk(tx_valid == 1'b0, "R9 idle after frame", {31'd0, tx_valid}, 32'd0);
    rd_reg(A_FLAG, r);
    chk(r == 32'd1, "R9 flag sticky", r, 32'd1);
    wr_reg(A_FLAG, 32'd1);
    rd_reg(A_FLAG, r);
    chk(r == 32'd0, "R10 flag cleared", r, 32'd0);

    // R10: clamp
    wr_reg(A_LEN0 + 1, 32'd3000);
    rd_reg(A_LEN0 + 1, r);
    chk(r == 32'd2048, "R10 clamped length", r, 32'd2048);
    rd_reg(A_FLAG, r);
    chk(r == 32'd2, "R10 clamp flag", r, 32'd2);
    wr_reg(A_FLAG, 32'd2);
    rd_reg(A_FLAG, r);
    chk(r == 32'd0, "R10 clamp flag cleared", r, 32'd0);

    // R6: zero length
    wr_reg(A_LEN0, 32'd0);
    wr_reg(A_CTL0, 32'd1);
    chk(tx_valid == 1'b0, "R6 no output", {31'd0, tx_valid}, 32'd0);
    rd_reg(A_CTL0, r);
    chk(r == 32'd0, "R6 not busy", r, 32'd0);
    repeat (3) @(negedge clk);
    chk(tx_valid == 1'b0, "R6 still idle", {31'd0, tx_valid}, 32'd0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule